// File: doc/BRIEF.md
# Configurable Interrupt Routing Matrix

This block steers a wide set of active-high interrupt request lines onto a smaller set of lines that feed a downstream interrupt controller. Each request line owns one 32-bit steering word on a simple register bus. The word holds a route-enable flag and the number of the output line the request should drive. Any number of enabled requests may name the same output. That output then carries the OR of all of them, which suits active-high level sources sharing one line. A rising-edge source is normally given an output that no other request uses.

Software can also read the current synchronized level of every request line as a short run of 32-bit status words. The status is reported whether or not a line is routed, so a handler on a shared output can find which source is active. Requests pass through a two-flop synchronizer, and the outputs are registered, so the block can take requests from any clock domain.

Top module: `irq_route_matrix`

## Requirements
- R1: While `rst_n` is low at a clock edge, every steering word is cleared, all of `irq_out` is low after that edge and `bus_rdata` is zero.
- R2: The steering word of request n is at byte offset 4*n (offsets 0x000 to 0x1FC). A write stores bit 31 as the route enable and bits 4:0 as the output number. A read returns those bits in the same places with every other bit zero.
- R3: Each output o is the OR of all requests whose enable is set and whose output number equals o. A request level applied before clock edge k shows on `irq_out` after edge k+2: two synchronizer stages and one output register.
- R4: Several enabled requests that name the same output are OR-merged onto it. The output stays high while any one of them is high.
- R5: An output number of 24 or above drives no output, even when the enable is set.
- R6: Writing a word with bit 31 clear, for example zero, removes that request from every output from the next edge onward.
- R7: Status word w, at byte offset 0x420 + 4*w for w = 0 to 3, holds in bit k the synchronized level of request 32*w + k, whether or not the request is enabled.
- R8: Writes to the status offsets 0x420 to 0x42F change no steering word and no output.
- R9: Reads of any offset that is neither a steering word nor a status word, including 0x200 to 0x41C and 0x430 and above, return zero.
- R10: Read data is registered. It appears on `bus_rdata` after the clock edge that samples `bus_rd` high and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | 128 | Active-high interrupt requests, may be asynchronous |
| irq_out | output | 24 | Registered outputs toward the interrupt controller |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe, one word per cycle |
| bus_addr | input | 12 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
A corrupted steering word shows as a wrong `irq_out` bit three edges after the next request change on that line. It also shows as a wrong value when the word is read back one edge after the read strobe. The bench therefore compares every output and sampled words after each random reconfiguration. A slip in the synchronizer or output register shows as a one-cycle shift in the latency check. A bad address decode shows as status writes that disturb the outputs, or as unmapped reads that return nonzero data on the next edge.

// File: rtl/irq_rm_pkg.sv
// Shared types and address classification for the interrupt routing matrix.
// Assumes word-granular addressing: callers pass the byte address shifted
// right by two.
package irq_rm_pkg;

    // Which register region a word address falls into.
    typedef enum logic [1:0] {
        REG_CFG  = 2'd0,
        REG_STAT = 2'd1,
        REG_NONE = 2'd2
    } region_e;

    // Classify a word address against the steering and status windows.
    function automatic region_e classify(
        input logic [31:0] word,
        input logic [31:0] n_cfg,
        input logic [31:0] stat0,
        input logic [31:0] n_stat
    );
        if (word < n_cfg)
            return REG_CFG;
        else if ((word >= stat0) && (word < stat0 + n_stat))
            return REG_STAT;
        else
            return REG_NONE;
    endfunction

endpackage

// File: rtl/irq_rm_sync.sv
// Two-flop synchronizer for a vector of independent request lines.
// Assumes each bit is a slow level (or a pulse wider than two clocks), so
// no bit-to-bit coherency is needed.
module irq_rm_sync #(
    parameter int WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1;

    // Two back-to-back flops resolve metastability before any consumer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end

endmodule

// File: rtl/irq_rm_cfg.sv
// Steering word storage: one enable flag and one output number per request.
// Assumes a single-cycle write strobe and that the steering window starts at
// word 0. Only the enable bit and the low SEL_W bits are kept.
module irq_rm_cfg
    import irq_rm_pkg::*;
#(
    parameter int NUM_IN    = 128,
    parameter int SEL_W     = 5,
    parameter int AW        = 12,
    parameter int DW        = 32,
    parameter int STAT_BASE = 'h420,
    parameter int NUM_STAT  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    output logic [NUM_IN-1:0]           cfg_en,
    output logic [NUM_IN-1:0][SEL_W-1:0] cfg_sel
);

    localparam int WA_W   = AW - 2;
    localparam int EN_BIT = DW - 1;
    localparam int STAT0  = STAT_BASE / 4;

    logic [WA_W-1:0]   word;
    region_e           region;
    logic [NUM_IN-1:0] hit;

    // Word address and region for the current bus access.
    always_comb begin
        word   = addr[AW-1:2];
        region = classify(32'(word), 32'(NUM_IN), 32'(STAT0), 32'(NUM_STAT));
    end

    // One write hit flag per steering word.
    for (genvar i = 0; i < NUM_IN; i++) begin : g_hit
        assign hit[i] = wr_en && (region == REG_CFG) && (word == WA_W'(i));
    end

    // Update the addressed steering word; everything clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en  <= '0;
            cfg_sel <= '0;
        end else begin
            for (int i = 0; i < NUM_IN; i++) begin
                if (hit[i]) begin
                    cfg_en[i]  <= wdata[EN_BIT];
                    cfg_sel[i] <= wdata[SEL_W-1:0];
                end
            end
        end
    end

    wire unused_wbits = ^{addr[1:0], wdata[EN_BIT-1:SEL_W]};

endmodule

// File: rtl/irq_rm_route.sv
// OR-merge network: each output is the OR of the synchronized requests that
// are enabled and name that output. Output numbers at or above NUM_OUT match
// nothing. Outputs are registered so they reach the controller glitch-free.
module irq_rm_route #(
    parameter int NUM_IN  = 128,
    parameter int NUM_OUT = 24,
    parameter int SEL_W   = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_IN-1:0]            req,
    input  logic [NUM_IN-1:0]            cfg_en,
    input  logic [NUM_IN-1:0][SEL_W-1:0] cfg_sel,
    output logic [NUM_OUT-1:0]           out_q
);

    logic [NUM_OUT-1:0] out_d;

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        logic [NUM_IN-1:0] term;

        // Per-request contribution to this output.
        for (genvar i = 0; i < NUM_IN; i++) begin : g_term
            assign term[i] = req[i] && cfg_en[i] && (cfg_sel[i] == SEL_W'(o));
        end

        // Wired-OR of every contribution.
        assign out_d[o] = |term;
    end

    // Register the merged outputs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

endmodule

// File: rtl/irq_rm_readback.sv
// Register read path: steering words, status words and zero elsewhere.
// Assumes NUM_IN is a multiple of 32 so status words are fully populated.
// Read data is captured on the read strobe and held until the next read.
module irq_rm_readback
    import irq_rm_pkg::*;
#(
    parameter int NUM_IN    = 128,
    parameter int SEL_W     = 5,
    parameter int AW        = 12,
    parameter int DW        = 32,
    parameter int STAT_BASE = 'h420,
    parameter int NUM_STAT  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [AW-1:0]                addr,
    input  logic [NUM_IN-1:0]            req,
    input  logic [NUM_IN-1:0]            cfg_en,
    input  logic [NUM_IN-1:0][SEL_W-1:0] cfg_sel,
    output logic [DW-1:0]                rdata
);

    localparam int WA_W       = AW - 2;
    localparam int IDX_W      = $clog2(NUM_IN);
    localparam int STAT0      = STAT_BASE / 4;
    localparam int STAT_IDX_W = (NUM_STAT > 1) ? $clog2(NUM_STAT) : 1;
    localparam int PAD_W      = DW - 1 - SEL_W;

    logic [WA_W-1:0]       word;
    region_e               region;
    logic [31:0]           stat_off;
    logic [STAT_IDX_W-1:0] stat_idx;
    logic [IDX_W-1:0]      cfg_idx;
    logic [DW-1:0]         rd_next;

    // Decode the access and select the word to return.
    always_comb begin
        word     = addr[AW-1:2];
        region   = classify(32'(word), 32'(NUM_IN), 32'(STAT0), 32'(NUM_STAT));
        stat_off = 32'(word) - 32'(STAT0);
        stat_idx = stat_off[STAT_IDX_W-1:0];
        cfg_idx  = word[IDX_W-1:0];
        case (region)
            REG_CFG:  rd_next = {cfg_en[cfg_idx], {PAD_W{1'b0}}, cfg_sel[cfg_idx]};
            REG_STAT: rd_next = req[32*stat_idx +: 32];
            default:  rd_next = '0;
        endcase
    end

    // Capture read data on a read strobe, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_next;
    end

    wire unused_rbits = ^{addr[1:0], stat_off};

endmodule

// File: rtl/irq_route_matrix.sv
// Top of the interrupt routing matrix. Requests are synchronized, then
// steered through per-request enable and output-number words onto OR-merged
// registered outputs. A register bus reaches the steering words and a
// read-only status view of the synchronized request levels.
// Assumes: synchronous active-low reset; single-cycle bus strobes; byte
// addresses with bits 1:0 ignored; NUM_IN a multiple of 32.
module irq_route_matrix #(
    parameter int NUM_IN    = 128,
    parameter int NUM_OUT   = 24,
    parameter int AW        = 12,
    parameter int DW        = 32,
    parameter int STAT_BASE = 'h420
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IN-1:0]  irq_in,
    output logic [NUM_OUT-1:0] irq_out,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata
);

    localparam int SEL_W    = $clog2(NUM_OUT);
    localparam int NUM_STAT = NUM_IN / 32;

    logic [NUM_IN-1:0]            req_sync;
    logic [NUM_IN-1:0]            cfg_en;
    logic [NUM_IN-1:0][SEL_W-1:0] cfg_sel;

    irq_rm_sync #(
        .WIDTH (NUM_IN)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (req_sync)
    );

    irq_rm_cfg #(
        .NUM_IN    (NUM_IN),
        .SEL_W     (SEL_W),
        .AW        (AW),
        .DW        (DW),
        .STAT_BASE (STAT_BASE),
        .NUM_STAT  (NUM_STAT)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .cfg_en  (cfg_en),
        .cfg_sel (cfg_sel)
    );

    irq_rm_route #(
        .NUM_IN  (NUM_IN),
        .NUM_OUT (NUM_OUT),
        .SEL_W   (SEL_W)
    ) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_sync),
        .cfg_en  (cfg_en),
        .cfg_sel (cfg_sel),
        .out_q   (irq_out)
    );

    irq_rm_readback #(
        .NUM_IN    (NUM_IN),
        .SEL_W     (SEL_W),
        .AW        (AW),
        .DW        (DW),
        .STAT_BASE (STAT_BASE),
        .NUM_STAT  (NUM_STAT)
    ) u_rb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (bus_rd),
        .addr    (bus_addr),
        .req     (req_sync),
        .cfg_en  (cfg_en),
        .cfg_sel (cfg_sel),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/irq_route_matrix_chk.sv
// Property checker for the interrupt routing matrix, bound to the top.
// Watches the bus, the outputs and the steering storage.
module irq_route_matrix_chk
    import irq_rm_pkg::*;
#(
    parameter int NUM_IN    = 128,
    parameter int NUM_OUT   = 24,
    parameter int AW        = 12,
    parameter int DW        = 32,
    parameter int STAT_BASE = 'h420,
    parameter int SEL_W     = 5
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_wr,
    input logic                         bus_rd,
    input logic [AW-1:0]                bus_addr,
    input logic [DW-1:0]                bus_wdata,
    input logic [DW-1:0]                bus_rdata,
    input logic [NUM_OUT-1:0]           irq_out,
    input logic [NUM_IN-1:0]            cfg_en,
    input logic [NUM_IN-1:0][SEL_W-1:0] cfg_sel
);

    localparam int NUM_STAT = NUM_IN / 32;
    localparam int IDX_W    = $clog2(NUM_IN);

    region_e          region;
    logic [IDX_W-1:0] widx;
    logic             any_live_route;

    // Decode the bus access and find whether any route can reach an output.
    always_comb begin
        region = classify(32'(bus_addr[AW-1:2]), 32'(NUM_IN),
                          32'(STAT_BASE / 4), 32'(NUM_STAT));
        widx   = bus_addr[IDX_W+1:2];
        any_live_route = 1'b0;
        for (int i = 0; i < NUM_IN; i++)
            if (cfg_en[i] && (32'(cfg_sel[i]) < 32'(NUM_OUT)))
                any_live_route = 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0 && bus_rdata == '0));

    assert_no_route_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !any_live_route |=> (irq_out == '0));

    assert_disable_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && region == REG_CFG && !bus_wdata[DW-1]) |=> !cfg_en[$past(widx)]);

    assert_stat_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && region == REG_STAT) |=> ($stable(cfg_en) && $stable(cfg_sel)));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && region == REG_NONE) |=> (bus_rdata == '0));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && $past(rst_n)) |=> $stable(bus_rdata));

endmodule

bind irq_route_matrix irq_route_matrix_chk #(
    .NUM_IN    (NUM_IN),
    .NUM_OUT   (NUM_OUT),
    .AW        (AW),
    .DW        (DW),
    .STAT_BASE (STAT_BASE),
    .SEL_W     (SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .cfg_en    (cfg_en),
    .cfg_sel   (cfg_sel)
);

// File: tb/irq_route_matrix_bench.sv
module irq_route_matrix_bench;

    localparam int NI = 128;
    localparam int NO = 24;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NI-1:0]  irq_in = '0;
    logic [NO-1:0]  irq_out;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [11:0]    bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;

    int total = 0;
    int bad   = 0;

    bit m_en  [NI];
    int m_sel [NI];

    always #2 clk = ~clk;

    irq_route_matrix u_irq_route_matrix (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .irq_out   (irq_out),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [NO-1:0] exp_out(logic [NI-1:0] lv);
        logic [NO-1:0] r = '0;
        for (int i = 0; i < NI; i++)
            if (m_en[i] && lv[i] && m_sel[i] < NO) r[m_sel[i]] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] exp_cfg(int i);
        return {m_en[i], 26'b0, 5'(m_sel[i])};
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a < 12'h200) begin
            m_en[a[8:2]]  = d[31];
            m_sel[a[8:2]] = int'(d[4:0]);
        end
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2417));
        for (int i = 0; i < NI; i++) begin m_en[i] = 0; m_sel[i] = 0; end

        // R1: reset state
        irq_in = '1;
        repeat (3) @(negedge clk);
        chk("R1 out", 128'(irq_out), 0);
        chk("R1 rdata", 128'(bus_rdata), 0);
        rst_n = 1'b1;
        irq_in = '0;
        settle();
        rd(12'h010, d);
        chk("R1 cfg word", 128'(d), 0);
        irq_in = '1;
        settle();
        chk("R1 out low with no routes", 128'(irq_out), 0);
        irq_in = '0;

        // R3: exact latency, input 5 -> output 3
        wr(12'h014, 32'h8000_0003);
        settle();
        irq_in[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R3 not yet after two edges", 128'(irq_out[3]), 0);
        @(negedge clk);
        chk("R3 high after third edge", 128'(irq_out[3]), 1);

        // R4: three requests merged onto output 7
        wr(12'h040, 32'h8000_0007);
        wr(12'h0C4, 32'h8000_0007);
        wr(12'h1FC, 32'h8000_0007);
        irq_in = '0; irq_in[127] = 1'b1;
        settle();
        chk("R4 shared high via 127", 128'(irq_out), 128'(exp_out(irq_in)));
        irq_in[127] = 1'b0; irq_in[49] = 1'b1; irq_in[16] = 1'b1;
        settle();
        chk("R4 shared high via 16 and 49", 128'(irq_out[7]), 1);
        irq_in[16] = 1'b0;
        settle();
        chk("R4 shared held by 49", 128'(irq_out[7]), 1);

        // R5: out-of-range output number
        wr(12'h0C4, 32'h8000_0018);
        wr(12'h008, 32'h8000_001F);
        irq_in[2] = 1'b1;
        settle();
        chk("R5 index 24 and 31 drive nothing", 128'(irq_out), 128'(exp_out(irq_in)));
        rd(12'h0C4, d);
        chk("R2 readback index 24", 128'(d), 128'(32'h8000_0018));

        // R6: zero disconnects
        irq_in[5] = 1'b1;
        wr(12'h014, 32'h0000_0000);
        settle();
        chk("R6 zero write disconnects", 128'(irq_out[3]), 0);
        wr(12'h040, 32'h7FFF_FFE7);
        settle();
        chk("R6 enable clear with junk bits", 128'(irq_out), 128'(exp_out(irq_in)));
        rd(12'h040, d);
        chk("R2 masked readback", 128'(d), 128'(32'h0000_0007));

        // R8: status writes ignored
        irq_in = '1;
        wr(12'h420, 32'hFFFF_FFFF);
        wr(12'h42C, 32'h8000_0001);
        settle();
        chk("R8 outputs unchanged", 128'(irq_out), 128'(exp_out(irq_in)));
        rd(12'h000, d);
        chk("R8 cfg0 unchanged", 128'(d), 128'(exp_cfg(0)));
        rd(12'h004, d);
        chk("R8 cfg1 unchanged", 128'(d), 128'(exp_cfg(1)));

        // R9: unmapped reads
        rd(12'h200, d);  chk("R9 0x200", 128'(d), 0);
        rd(12'h41C, d);  chk("R9 0x41C", 128'(d), 0);
        rd(12'h430, d);  chk("R9 0x430", 128'(d), 0);
        rd(12'hFFC, d);  chk("R9 0xFFC", 128'(d), 0);

        // R10: hold between reads
        rd(12'h42C, d);
        repeat (3) @(negedge clk);
        chk("R10 rdata holds", 128'(bus_rdata), 128'(32'hFFFF_FFFF));

        // R7: status regardless of enable
        irq_in = {32'h1234_5678, 32'h0, 32'hDEAD_BEEF, 32'h8000_0001};
        settle();
        for (int w = 0; w < 4; w++) begin
            rd(12'(12'h420 + 4*w), d);
            chk("R7 status word", 128'(d), 128'(irq_in[32*w +: 32]));
        end

        // Random mix: R2, R3, R7
        for (int it = 0; it < 60; it++) begin
            for (int k = 0; k < 4; k++) begin
                int n = $urandom_range(0, NI-1);
                logic [31:0] v = $urandom;
                v[4:0] = 5'($urandom_range(0, 31));
                wr(12'(4*n), v);
            end
            irq_in = {$urandom & $urandom, $urandom & $urandom,
                      $urandom & $urandom, $urandom & $urandom};
            settle();
            chk("R3 random routing", 128'(irq_out), 128'(exp_out(irq_in)));
            begin
                int n = $urandom_range(0, NI-1);
                int w = $urandom_range(0, 3);
                rd(12'(4*n), d);
                chk("R2 random readback", 128'(d), 128'(exp_cfg(n)));
                rd(12'(12'h420 + 4*w), d);
                chk("R7 random status", 128'(d), 128'(irq_in[32*w +: 32]));
            end
        end

        // R1: reset again clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NI; i++) begin m_en[i] = 0; m_sel[i] = 0; end
        @(negedge clk);
        chk("R1 out after mid-run reset", 128'(irq_out), 0);
        settle();
        chk("R1 routes cleared", 128'(irq_out), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule